// File: doc/BRIEF.md
# Size-aligned packed register block

This block holds three narrow control registers packed into a single 32-bit bus word. Two of them are 8 bits wide and one is 16 bits wide. Each register starts at an address that is a multiple of its own size in bytes. It sits in the byte lanes of the bus word that match that start address. The address decode ignores the byte-within-word bits, so one strobe at any byte address of the word reaches all three registers in the same clock cycle.

Host logic drives a simple strobe bus: an address, a write strobe with write data and a per-bit write mask, and a read strobe. Writes take each register's value from its own lane slice of the write data, and only the bits whose mask bit is set change. A read ORs the gated value of every register, placed in its lane, into one word. That word is registered and appears on `rd_data` one cycle after the read strobe.

Top module: `pk_regblock`

## Requirements
- R1: A synchronous active-high `rst` clears all three registers to zero, and `rd_data` is zero in the cycle after reset.
- R2: A strobe reaches the registers only when `address[ADDR_W-1:2]` equals `BASE_ADDR[ADDR_W-1:2]`. The byte-within-word bits `address[1:0]` are ignored.
- R3: Register A sits at byte offset 0 on lanes [7:0], register B at byte offset 1 on lanes [15:8], and register C (16 bits) at byte offset 2 on lanes [31:16]. One write updates all three in the same cycle.
- R4: During a decoded write, every register bit whose `wr_mask` bit is 1 takes the matching `wr_data` bit. Every bit whose mask bit is 0 keeps its value.
- R5: A write whose mask is all zero in a register's lanes leaves that register unchanged.
- R6: In the cycle after a decoded `rd_stb`, `rd_data` equals {C, B, A} as the registers stood before that edge. A write in the same cycle is therefore not yet visible.
- R7: In the cycle after a cycle with no decoded read, `rd_data` is zero. This covers an idle bus and a read to another word.
- R8: A write to any other bus word leaves all three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| address | input | ADDR_W | Byte address |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | BUS_W | Write data, one lane per register |
| wr_mask | input | BUS_W | Per-bit write enable |
| rd_data | output | BUS_W | Registered merged read word |

## Verification
The bench builds the block with a 32-bit bus, an 8-bit address and `BASE_ADDR` = 0x24. A nonzero base makes the word-index compare meaningful. The neighbouring words at 0x20 and 0x28 become reachable as miss addresses that must leave the registers alone, and the four aliases 0x24 to 0x27 show that the byte bits are ignored. Because the three registers exactly fill the 32-bit word, a full-mask write and read-back covers every lane. Lane-selective masks can then target one register at a time.

// File: rtl/pkreg_pkg.sv
package pkreg_pkg;
  localparam int NREG = 3;
  // register size in bytes and byte offset from the block base
  localparam int REG_BYTES [NREG] = '{1, 1, 2};
  localparam int REG_OFF   [NREG] = '{0, 1, 2};

  function automatic int lane_lsb(input int idx, input int bus_bytes);
    return (REG_OFF[idx] % bus_bytes) * 8;
  endfunction

  function automatic int reg_width(input int idx);
    return REG_BYTES[idx] * 8;
  endfunction
endpackage

// File: rtl/pk_decode.sv
module pk_decode #(
  parameter int ADDR_W = 8,
  parameter int LANE_BITS = 2,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic [ADDR_W-1:0] address,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic              wr_valid,
  output logic              rd_valid
);
  logic sel;
  // compare the word index only; byte-lane bits are don't-care
  assign sel      = (address[ADDR_W-1:LANE_BITS] == OFFSET[ADDR_W-1:LANE_BITS]);
  assign wr_valid = sel & wr_stb;
  assign rd_valid = sel & rd_stb;
endmodule

// File: rtl/pk_lane_reg.sv
module pk_lane_reg #(
  parameter int BUS_W = 32,
  parameter int W = 8,
  parameter int LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             rd_valid,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [BUS_W-1:0] wr_mask,
  output logic [BUS_W-1:0] rd_lane,
  output logic [BUS_W-1:0] image
);
  logic [W-1:0] q;
  logic [W-1:0] d_slice, m_slice;

  assign d_slice = wr_data[LSB +: W];
  assign m_slice = wr_mask[LSB +: W];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_valid) begin
      q <= (d_slice & m_slice) | (q & ~m_slice);
    end
  end

  assign image   = BUS_W'(q) << LSB;
  assign rd_lane = rd_valid ? image : '0;
endmodule

// File: rtl/pk_read_merge.sv
module pk_read_merge #(
  parameter int BUS_W = 32,
  parameter int N = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0][BUS_W-1:0]   lanes,
  output logic [BUS_W-1:0]          rd_data
);
  logic [BUS_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++) merged = merged | lanes[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= merged;
  end
endmodule

// File: rtl/pk_regblock.sv
module pk_regblock #(
  parameter int BUS_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [BUS_W-1:0]  wr_mask,
  output logic [BUS_W-1:0]  rd_data
);
  import pkreg_pkg::*;

  localparam int BUS_BYTES = BUS_W / 8;
  localparam int LANE_BITS = $clog2(BUS_BYTES);

  logic [NREG-1:0][BUS_W-1:0] rd_lanes;
  logic [NREG-1:0][BUS_W-1:0] images;
  logic [BUS_W-1:0]           reg_image;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(int'(BASE_ADDR) + REG_OFF[i]);
    logic wv, rv;

    pk_decode #(.ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS), .OFFSET(OFF)) u_dec (
      .address (address),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .wr_valid(wv),
      .rd_valid(rv)
    );

    pk_lane_reg #(.BUS_W(BUS_W), .W(reg_width(i)), .LSB(lane_lsb(i, BUS_BYTES))) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_valid(wv),
      .rd_valid(rv),
      .wr_data (wr_data),
      .wr_mask (wr_mask),
      .rd_lane (rd_lanes[i]),
      .image   (images[i])
    );
  end

  always_comb begin
    reg_image = '0;
    for (int i = 0; i < NREG; i++) reg_image = reg_image | images[i];
  end

  pk_read_merge #(.BUS_W(BUS_W), .N(NREG)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .lanes  (rd_lanes),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pk_regblock_chk.sv
module pk_regblock_chk #(
  parameter int BUS_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] address,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [BUS_W-1:0]  wr_data,
  input logic [BUS_W-1:0]  wr_mask,
  input logic [BUS_W-1:0]  rd_data,
  input logic [BUS_W-1:0]  reg_image
);
  localparam int LB = $clog2(BUS_W / 8);

  function automatic logic [BUS_W-1:0] cover_mask();
    logic [BUS_W-1:0] m = '0;
    for (int i = 0; i < pkreg_pkg::NREG; i++)
      for (int b = 0; b < pkreg_pkg::reg_width(i); b++)
        m[pkreg_pkg::lane_lsb(i, BUS_W / 8) + b] = 1'b1;
    return m;
  endfunction
  localparam logic [BUS_W-1:0] COVER = cover_mask();

  logic hit;
  logic rst_d;
  assign hit = (address[ADDR_W-1:LB] == BASE_ADDR[ADDR_W-1:LB]);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) AST_RESET_CLEAR: assert (reg_image == '0 && rd_data == '0); // R1
  end

  AST_WORD_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && hit) |=> rd_data == $past(reg_image)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && hit) |=> rd_data == '0); // R7

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && hit) |=> $stable(reg_image)); // R8

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_mask == '0) |=> $stable(reg_image)); // R5

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && hit && (&wr_mask)) |=> reg_image == ($past(wr_data) & COVER)); // R3
endmodule

bind pk_regblock pk_regblock_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/pk_regblock_tb.sv
module pk_regblock_tb;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 8'h24;

  logic clk = 0;
  logic rst = 1;
  logic [ADDR_W-1:0] address = '0;
  logic wr_stb = 0, rd_stb = 0;
  logic [BUS_W-1:0] wr_data = '0, wr_mask = '0;
  logic [BUS_W-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [BUS_W-1:0] mdl = '0;
  logic [BUS_W-1:0] q_exp[$];
  string q_tag[$];
  logic sample_now = 0;

  always #5 clk = ~clk;

  pk_regblock #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst), .address(address), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data)
  );

  function automatic bit is_hit(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2] == BASE[ADDR_W-1:2];
  endfunction

  task automatic check(string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare the registered read word one cycle after the strobe
  always @(posedge clk) sample_now <= rd_stb;
  always @(negedge clk) begin
    if (sample_now && q_exp.size() > 0) check(q_tag.pop_front(), rd_data, q_exp.pop_front());
  end

  task automatic do_write(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] d, logic [BUS_W-1:0] m);
    @(negedge clk);
    address = a; wr_data = d; wr_mask = m; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
    if (is_hit(a)) mdl = (d & m) | (mdl & ~m);
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, string tag);
    @(negedge clk);
    address = a; rd_stb = 1;
    q_exp.push_back(is_hit(a) ? mdl : '0);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic do_rw(logic [ADDR_W-1:0] a, logic [BUS_W-1:0] d, logic [BUS_W-1:0] m, string tag);
    @(negedge clk);
    address = a; wr_data = d; wr_mask = m; wr_stb = 1; rd_stb = 1;
    q_exp.push_back(is_hit(a) ? mdl : '0);
    q_tag.push_back(tag);
    @(negedge clk);
    wr_stb = 0; rd_stb = 0;
    if (is_hit(a)) mdl = (d & m) | (mdl & ~m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 rd_data after reset", rd_data, '0);
    do_read(8'h24, "R1 registers zero after reset");

    do_write(8'h24, 32'hA1B2_C3D4, 32'hFFFF_FFFF);
    do_read(8'h24, "R3 full word write all lanes");
    do_read(8'h27, "R2 byte bits ignored on read");

    do_write(8'h26, 32'h1122_3344, 32'h00FF_00FF);
    do_read(8'h25, "R4 partial mask via alias address");

    do_write(8'h24, 32'hFFFF_FFFF, 32'h5A5A_5A5A);
    do_read(8'h24, "R4 alternating bit mask");

    do_write(8'h24, 32'h0000_7700, 32'h0000_FF00);
    do_read(8'h24, "R5 only register B written");

    do_write(8'h24, 32'hDEAD_BEEF, 32'h0000_0000);
    do_read(8'h24, "R5 zero mask leaves all unchanged");

    do_write(8'h20, 32'h0000_0000, 32'hFFFF_FFFF);
    do_write(8'h28, 32'h0000_0000, 32'hFFFF_FFFF);
    do_read(8'h24, "R8 writes to other words ignored");
    do_read(8'h28, "R7 read of another word is zero");

    do_rw(8'h24, 32'h0BAD_F00D, 32'hFFFF_FFFF, "R6 same-cycle read returns old value");
    do_read(8'h24, "R6 write visible on next read");

    @(negedge clk);
    @(negedge clk);
    check("R7 idle bus reads zero", rd_data, '0);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; mdl = '0;
    check("R1 rd_data after mid-run reset", rd_data, '0);
    do_read(8'h26, "R1 mid-run reset clears registers");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule